// File: doc/BRIEF.md
# Digital Clock-Recovery Phase Selector

This block is the digital core of a receive timing-recovery loop. Each cycle a bang-bang phase detector tells it whether the current retiming phase samples the data too early or too late. A signed proportional-plus-integral accumulator smooths these votes. When the accumulator crosses a programmable threshold, the block moves a phase index by one position. The index is split into a coarse tap select, which picks one phase of a shared multi-phase clock, and a fine interpolation step between adjacent taps. The index wraps, so the loop can follow a frequency offset indefinitely.

When the detector stays silent for a set number of cycles, the block enters a hunting state. In that state it clears its filter and ramps the phase steadily upward until votes return.

A hold input freezes the whole loop and its parallel output, which is used when the line carries no valid data. A test input turns the parallel output into a view of the accumulator. In that mode two asynchronous pulse inputs nudge the accumulator up or down by one count per pulse.

Top module: `cdr_phase_sel`

## Requirements
- R1: While `rst_n` is low, the phase index, the accumulator, the integrator, `rx_word`, `step_up` and `step_dn` are all zero.
- R2: In tracking mode a vote counts as +1 when only `vote_late` is high, as -1 when only `vote_early` is high, and as 0 otherwise. Each cycle the integrator becomes the sum of itself and the vote, clamped to ±INT_LIM. The sum S is accumulator + KP·vote + the new integrator value. If S ≥ T, the block steps up and keeps S−T. If S ≤ −T, it steps down and keeps S+T. Otherwise it keeps S. T is `thr`, or 1 when `thr` is 0.
- R3: A step moves the phase index by +1 or −1 modulo 2^(COARSE_W+FINE_W), in the same clock edge as the decision. `step_up` or `step_dn` is high for the cycle after that edge.
- R4: `coarse_sel` is the phase index divided by 2^FINE_W, and `fine_sel` is the phase index modulo 2^FINE_W.
- R5: After IDLE_LIM consecutive tracking edges without a vote, the block is hunting. On each further edge without a vote it clears the accumulator and the integrator, and it steps up once every RAMP_DIV edges.
- R6: A vote ends hunting at once. That edge is processed as a normal tracking edge, and the silence count restarts from zero.
- R7: While `lckref_n` is low, votes, test pulses and `rx_data_in` have no effect: the phase index, the accumulator and `rx_word` keep their values. This mode takes priority over test mode.
- R8: While `test_en` is high (and `lckref_n` is high), votes are ignored and no step occurs. Each rising edge on `tst_inc` adds 1 to the accumulator, and each rising edge on `tst_dec` subtracts 1. `rx_word` shows the accumulator sign-extended to RX_W bits, one edge late.
- R9: The accumulator never leaves ±(2^(ACC_W−1)−1). Results beyond that range are clamped.
- R10: `step_up` and `step_dn` are never high together.
- R11: Outside the hold and test modes, `rx_word` takes the value of `rx_data_in` on every edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Loop clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lckref_n | input | 1 | Low: hold loop and parallel output |
| test_en | input | 1 | Accumulator test/observe mode |
| vote_early | input | 1 | Phase detector: sampling early, step down |
| vote_late | input | 1 | Phase detector: sampling late, step up |
| thr | input | ACC_W-1 | Step threshold (0 treated as 1) |
| tst_inc | input | 1 | Asynchronous increment pulse (test mode) |
| tst_dec | input | 1 | Asynchronous decrement pulse (test mode) |
| rx_data_in | input | RX_W | Deserialized receive word |
| coarse_sel | output | COARSE_W | Selected clock tap |
| fine_sel | output | FINE_W | Interpolation step between taps |
| step_up | output | 1 | Phase advanced at the last edge |
| step_dn | output | 1 | Phase retarded at the last edge |
| rx_word | output | RX_W | Receive word or accumulator view |

## Verification
The bench builds the block with COARSE_W=2, FINE_W=2, ACC_W=8, KP=2, INT_LIM=3, IDLE_LIM=8 and RAMP_DIV=4, with a threshold of 5. The 16-position index then wraps in both directions within a few dozen votes. Silence reaches the hunting ramp in eight cycles. A few hundred test pulses drive the 8-bit accumulator into both clamps. Each cycle of each vote pattern is compared against an arithmetic model of the filter, the index and the hunting timer.

// File: rtl/cdr_pkg.sv
`timescale 1ns/1ps
package cdr_pkg;

  typedef enum logic [1:0] {
    MODE_TRACK = 2'd0,
    MODE_HUNT  = 2'd1,
    MODE_HOLD  = 2'd2,
    MODE_TEST  = 2'd3
  } mode_e;

  // clamp a value into [-lim, lim]
  function automatic int clamp_sym(input int x, input int lim);
    if (x > lim)       return lim;
    else if (x < -lim) return -lim;
    else               return x;
  endfunction

  // zero threshold behaves as one
  function automatic int eff_thr(input int t);
    return (t < 1) ? 1 : t;
  endfunction

endpackage

// File: rtl/cdr_edge_sync.sv
`timescale 1ns/1ps
module cdr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], async_in};
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/cdr_loop_filter.sv
`timescale 1ns/1ps
module cdr_loop_filter
  import cdr_pkg::*;
#(
  parameter int ACC_W   = 10,
  parameter int KP      = 4,
  parameter int INT_LIM = 15
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  mode_e                   mode,
  input  logic signed [1:0]       vote,
  input  logic [ACC_W-2:0]        thr,
  input  logic                    inc,
  input  logic                    dec,
  output logic signed [ACC_W-1:0] acc,
  output logic                    req_up,
  output logic                    req_dn
);
  localparam int ACC_MAX = (1 << (ACC_W-1)) - 1;
  localparam int INT_W   = $clog2(INT_LIM+1) + 1;

  logic signed [ACC_W-1:0] acc_q;
  logic signed [INT_W-1:0] int_q;
  int acc_d, int_d, int_n, sum, t_i, v_i;

  always_comb begin
    v_i    = int'(vote);
    t_i    = eff_thr(int'(thr));
    int_n  = clamp_sym(int'(int_q) + v_i, INT_LIM);
    sum    = int'(acc_q) + KP * v_i + int_n;
    acc_d  = int'(acc_q);
    int_d  = int'(int_q);
    req_up = 1'b0;
    req_dn = 1'b0;
    unique case (mode)
      MODE_TRACK: begin
        int_d = int_n;
        if (sum >= t_i) begin
          req_up = 1'b1;
          acc_d  = clamp_sym(sum - t_i, ACC_MAX);
        end else if (sum <= -t_i) begin
          req_dn = 1'b1;
          acc_d  = clamp_sym(sum + t_i, ACC_MAX);
        end else begin
          acc_d  = clamp_sym(sum, ACC_MAX);
        end
      end
      MODE_HUNT: begin
        acc_d = 0;
        int_d = 0;
      end
      MODE_TEST: acc_d = clamp_sym(int'(acc_q) + int'(inc) - int'(dec), ACC_MAX);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      int_q <= '0;
    end else begin
      acc_q <= ACC_W'(acc_d);
      int_q <= INT_W'(int_d);
    end
  end

  assign acc = acc_q;

  AST_TEST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_TEST) |=> ((acc_q == $past(acc_q)) || (acc_q == $past(acc_q) + ACC_W'(1)) ||
                            (acc_q == $past(acc_q) - ACC_W'(1)))); // R8
  AST_HUNT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HUNT) |=> (acc_q == '0 && int_q == '0)); // R5
  AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(acc_q) <= ACC_MAX) && (int'(acc_q) >= -ACC_MAX)); // R9
  AST_HOLD_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HOLD) |=> $stable(acc_q)); // R7
endmodule

// File: rtl/cdr_hunt_ramp.sv
`timescale 1ns/1ps
module cdr_hunt_ramp #(
  parameter int IDLE_LIM = 64,
  parameter int RAMP_DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic has_vote,
  output logic hunt,
  output logic ramp_step
);
  localparam int IW = $clog2(IDLE_LIM + 1);
  localparam int RW = (RAMP_DIV > 1) ? $clog2(RAMP_DIV) : 1;
  localparam logic [IW-1:0] IDLE_TOP = IW'(IDLE_LIM);
  localparam logic [RW-1:0] RAMP_TOP = RW'(RAMP_DIV - 1);

  logic [IW-1:0] idle_q;
  logic [RW-1:0] ramp_q;

  assign hunt      = (idle_q == IDLE_TOP);
  assign ramp_step = enable && !has_vote && hunt && (ramp_q == RAMP_TOP);

  always_ff @(posedge clk) begin
    if (!rst_n || !enable || has_vote) begin
      idle_q <= '0;
      ramp_q <= '0;
    end else if (hunt) begin
      ramp_q <= (ramp_q == RAMP_TOP) ? '0 : ramp_q + RW'(1);
    end else begin
      idle_q <= idle_q + IW'(1);
      ramp_q <= '0;
    end
  end

  AST_VOTE_ENDS_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && has_vote) |=> !hunt); // R6
endmodule

// File: rtl/cdr_phase_index.sv
`timescale 1ns/1ps
module cdr_phase_index #(
  parameter int COARSE_W = 3,
  parameter int FINE_W   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                up,
  input  logic                dn,
  output logic [COARSE_W-1:0] coarse_sel,
  output logic [FINE_W-1:0]   fine_sel
);
  localparam int IDX_W = COARSE_W + FINE_W;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  idx_q <= '0;
    else if (up) idx_q <= idx_q + IDX_W'(1);
    else if (dn) idx_q <= idx_q - IDX_W'(1);
  end

  assign coarse_sel = idx_q[IDX_W-1:FINE_W];
  assign fine_sel   = idx_q[FINE_W-1:0];

  AST_IDX_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (up && !dn) |=> (idx_q == $past(idx_q) + IDX_W'(1))); // R3
  AST_IDX_DN: assert property (@(posedge clk) disable iff (!rst_n)
    (dn && !up) |=> (idx_q == $past(idx_q) - IDX_W'(1))); // R3
  AST_IDX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!up && !dn) |=> $stable(idx_q)); // R3
endmodule

// File: rtl/cdr_phase_sel.sv
`timescale 1ns/1ps
module cdr_phase_sel
  import cdr_pkg::*;
#(
  parameter int COARSE_W    = 3,
  parameter int FINE_W      = 3,
  parameter int ACC_W       = 10,
  parameter int RX_W        = 10,
  parameter int KP          = 4,
  parameter int INT_LIM     = 15,
  parameter int IDLE_LIM    = 64,
  parameter int RAMP_DIV    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lckref_n,
  input  logic                test_en,
  input  logic                vote_early,
  input  logic                vote_late,
  input  logic [ACC_W-2:0]    thr,
  input  logic                tst_inc,
  input  logic                tst_dec,
  input  logic [RX_W-1:0]     rx_data_in,
  output logic [COARSE_W-1:0] coarse_sel,
  output logic [FINE_W-1:0]   fine_sel,
  output logic                step_up,
  output logic                step_dn,
  output logic [RX_W-1:0]     rx_word
);
  // named internal events
  logic signed [1:0]       vote_v;
  logic                    has_vote;
  logic                    hunt;
  logic                    ramp_step;
  logic                    flt_up, flt_dn;
  logic                    step_up_w, step_dn_w;
  logic                    loop_live;
  logic [1:0]              pulse_rise;
  logic signed [ACC_W-1:0] acc;
  logic [RX_W-1:0]         acc_view;
  mode_e                   mode;

  assign vote_v   = (vote_late && !vote_early) ? 2'sb01 :
                    (vote_early && !vote_late) ? 2'sb11 : 2'sb00;
  assign has_vote = (vote_v != 2'sb00);
  assign loop_live = lckref_n && !test_en;

  always_comb begin
    if (!lckref_n)             mode = MODE_HOLD;
    else if (test_en)          mode = MODE_TEST;
    else if (hunt && !has_vote) mode = MODE_HUNT;
    else                       mode = MODE_TRACK;
  end

  // test pulse synchronizers: index 0 increments, index 1 decrements
  for (genvar g = 0; g < 2; g++) begin : g_pulse
    cdr_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in ((g == 0) ? tst_inc : tst_dec),
      .rise     (pulse_rise[g])
    );
  end

  cdr_loop_filter #(.ACC_W(ACC_W), .KP(KP), .INT_LIM(INT_LIM)) filt_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (mode),
    .vote   (vote_v),
    .thr    (thr),
    .inc    (pulse_rise[0]),
    .dec    (pulse_rise[1]),
    .acc    (acc),
    .req_up (flt_up),
    .req_dn (flt_dn)
  );

  cdr_hunt_ramp #(.IDLE_LIM(IDLE_LIM), .RAMP_DIV(RAMP_DIV)) hunt_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (loop_live),
    .has_vote  (has_vote),
    .hunt      (hunt),
    .ramp_step (ramp_step)
  );

  assign step_up_w = flt_up | ramp_step;
  assign step_dn_w = flt_dn;

  cdr_phase_index #(.COARSE_W(COARSE_W), .FINE_W(FINE_W)) idx_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .up         (step_up_w),
    .dn         (step_dn_w),
    .coarse_sel (coarse_sel),
    .fine_sel   (fine_sel)
  );

  if (RX_W > ACC_W) begin : g_ext
    assign acc_view = {{(RX_W-ACC_W){acc[ACC_W-1]}}, acc};
  end else begin : g_trunc
    assign acc_view = acc[RX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_up <= 1'b0;
      step_dn <= 1'b0;
      rx_word <= '0;
    end else begin
      step_up <= step_up_w;
      step_dn <= step_dn_w;
      if (mode == MODE_TEST)      rx_word <= acc_view;
      else if (mode != MODE_HOLD) rx_word <= rx_data_in;
    end
  end

  AST_STEP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_up && step_dn)); // R10
  AST_HOLD_RX: assert property (@(posedge clk) disable iff (!rst_n)
    !lckref_n |=> $stable(rx_word)); // R7
  AST_HOLD_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    !lckref_n |=> ($stable(coarse_sel) && $stable(fine_sel))); // R7
  AST_TEST_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (lckref_n && test_en) |=> (!step_up && !step_dn)); // R8
endmodule

// File: tb/cdr_phase_sel_tb.sv
`timescale 1ns/1ps
module cdr_phase_sel_tb_top;
  localparam int CW = 2, FW = 2, AW = 8, RW = 10;
  localparam int KP = 2, ILIM = 3, IDLE = 8, RDIV = 4, THR = 5;
  localparam int NPH = 1 << (CW + FW);
  localparam int AMAX = (1 << (AW - 1)) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0, lckref_n = 1'b1, test_en = 1'b0;
  logic vote_early = 1'b0, vote_late = 1'b0, tst_inc = 1'b0, tst_dec = 1'b0;
  logic [AW-2:0] thr = AW'(THR);
  logic [RW-1:0] rx_data_in = '0;
  logic [CW-1:0] coarse_sel;
  logic [FW-1:0] fine_sel;
  logic step_up, step_dn;
  logic [RW-1:0] rx_word;

  int checks = 0, failures = 0;
  int m_acc = 0, m_int = 0, m_idx = 0, m_idle = 0, m_ramp = 0;
  bit m_up = 0, m_dn = 0;

  always #10 clk = ~clk;

  cdr_phase_sel #(.COARSE_W(CW), .FINE_W(FW), .ACC_W(AW), .RX_W(RW), .KP(KP),
    .INT_LIM(ILIM), .IDLE_LIM(IDLE), .RAMP_DIV(RDIV), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .lckref_n(lckref_n), .test_en(test_en),
    .vote_early(vote_early), .vote_late(vote_late), .thr(thr),
    .tst_inc(tst_inc), .tst_dec(tst_dec), .rx_data_in(rx_data_in),
    .coarse_sel(coarse_sel), .fine_sel(fine_sel), .step_up(step_up),
    .step_dn(step_dn), .rx_word(rx_word));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int lim(input int x, input int l);
    return (x > l) ? l : ((x < -l) ? -l : x);
  endfunction

  task automatic model_reset();
    m_acc = 0; m_int = 0; m_idx = 0; m_idle = 0; m_ramp = 0; m_up = 0; m_dn = 0;
  endtask

  // one tracking/hunting cycle: drive at negedge, model edge, sample next negedge
  task automatic tick(input bit e, input bit l, input string tag);
    int v, s;
    vote_early = e; vote_late = l;
    rx_data_in = rx_data_in + RW'(37);
    v = (l && !e) ? 1 : ((e && !l) ? -1 : 0);
    @(posedge clk);
    m_up = 0; m_dn = 0;
    if (v == 0 && m_idle == IDLE) begin
      m_acc = 0; m_int = 0;
      if (m_ramp == RDIV - 1) begin m_ramp = 0; m_up = 1; end
      else m_ramp = m_ramp + 1;
    end else begin
      m_int = lim(m_int + v, ILIM);
      s = m_acc + KP * v + m_int;
      if (s >= THR)       begin m_up = 1; s = s - THR; end
      else if (s <= -THR) begin m_dn = 1; s = s + THR; end
      m_acc = lim(s, AMAX);
      m_ramp = 0;
      if (v != 0) m_idle = 0;
      else if (m_idle < IDLE) m_idle = m_idle + 1;
    end
    if (m_up) m_idx = (m_idx + 1) % NPH;
    if (m_dn) m_idx = (m_idx + NPH - 1) % NPH;
    @(negedge clk);
    chk(coarse_sel == CW'(m_idx >> FW) && fine_sel == FW'(m_idx % (1 << FW)),
        {tag, " R3 R4 phase"}, {coarse_sel, fine_sel}, m_idx);
    chk(step_up == m_up && step_dn == m_dn, {tag, " R2 step"},
        {step_up, step_dn}, {m_up, m_dn});
    chk(!(step_up && step_dn), "R10 exclusive", {step_up, step_dn}, 0);
  endtask

  task automatic read_acc(input string tag);
    test_en = 1'b1;
    @(negedge clk);
    chk(rx_word == RW'(m_acc), {tag, " R8 acc view"}, int'($signed(rx_word)), m_acc);
    test_en = 1'b0;
    m_idle = 0; m_ramp = 0;
  endtask

  task automatic pulse(input bit up);
    if (up) tst_inc = 1'b1; else tst_dec = 1'b1;
    repeat (2) @(negedge clk);
    tst_inc = 1'b0; tst_dec = 1'b0;
    repeat (3) @(negedge clk);
    m_acc = lim(m_acc + (up ? 1 : -1), AMAX);
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [CW-1:0] hc; logic [FW-1:0] hf; logic [RW-1:0] hr;
    int steps;
    repeat (3) @(negedge clk);
    chk(coarse_sel == 0 && fine_sel == 0, "R1 reset phase", {coarse_sel, fine_sel}, 0);
    chk(rx_word == 0 && !step_up && !step_dn, "R1 reset outputs", rx_word, 0);
    rst_n = 1'b1;
    model_reset();

    for (int i = 0; i < 40; i++) tick(1'b0, 1'b1, "late run");
    read_acc("after late run R2");
    for (int i = 0; i < 50; i++) tick(1'b1, 1'b0, "early run");
    read_acc("after early run R2");
    for (int i = 0; i < 30; i++) tick(i[0], ~i[0], "alternating");
    for (int i = 0; i < 60; i++)
      tick((i % 4 == 1) || (i % 5 == 0), (i % 3 == 0) || (i % 5 == 0), "mixed");
    read_acc("after mixed R2");

    // threshold 0 behaves as 1 (R2): every late vote steps
    thr = '0;
    for (int i = 0; i < 10; i++) begin
      vote_late = 1'b1; vote_early = 1'b0;
      @(negedge clk);
      chk(step_up && !step_dn, "R2 thr zero step", step_up, 1);
    end
    thr = AW'(THR);
    vote_late = 1'b0;
    // resync model with a reset
    rst_n = 1'b0; @(negedge clk);
    chk(coarse_sel == 0 && fine_sel == 0 && rx_word == 0, "R1 mid reset", rx_word, 0);
    rst_n = 1'b1; model_reset();

    // build integrator, then silence: R5 hunting ramp
    for (int i = 0; i < 6; i++) tick(1'b0, 1'b1, "pre-hunt");
    steps = 0;
    for (int i = 0; i < 40; i++) begin
      tick(1'b0, 1'b0, "R5 hunt");
      if (i >= 20 && step_up) steps++;
    end
    chk(steps == 5, "R5 ramp rate", steps, 5);
    read_acc("R5 hunt cleared");
    for (int i = 0; i < 12; i++) tick(1'b0, 1'b0, "R5 rehunt");
    for (int i = 0; i < 12; i++) tick(1'b1, 1'b0, "R6 vote ends hunt");
    for (int i = 0; i < 6; i++) tick(1'b0, 1'b0, "R6 recount");

    // R11 pass-through
    rx_data_in = 10'h2A5; @(negedge clk);
    chk(rx_word == 10'h2A5, "R11 data pass", rx_word, 10'h2A5);
    m_idle = (m_idle < IDLE) ? m_idle + 1 : m_idle;
    if (m_idle == IDLE) begin m_acc = 0; m_int = 0; end

    // R7 hold mode
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; model_reset();
    for (int i = 0; i < 7; i++) tick(1'b0, 1'b1, "pre-hold");
    lckref_n = 1'b0;
    hc = coarse_sel; hf = fine_sel; hr = rx_word;
    for (int i = 0; i < 12; i++) begin
      vote_late = 1'b1; test_en = i[2];
      tst_inc = i[1]; rx_data_in = RW'(i * 91);
      @(negedge clk);
      chk(coarse_sel == hc && fine_sel == hf, "R7 hold phase", {coarse_sel, fine_sel}, {hc, hf});
      chk(rx_word == hr, "R7 hold rx", rx_word, hr);
    end
    tst_inc = 1'b0; test_en = 1'b0; vote_late = 1'b0;
    repeat (3) @(negedge clk);
    lckref_n = 1'b1; m_idle = 0; m_ramp = 0;
    read_acc("R7 acc held");

    // R8 test pulses, votes ignored; R9 clamps
    test_en = 1'b1; vote_late = 1'b1;
    for (int i = 0; i < 6; i++) begin
      pulse(1'b1);
      chk(rx_word == RW'(m_acc), "R8 inc", int'($signed(rx_word)), m_acc);
      chk(coarse_sel == CW'(m_idx >> FW) && !step_up, "R8 no step", coarse_sel, m_idx >> FW);
    end
    for (int i = 0; i < 3; i++) begin
      pulse(1'b0);
      chk(rx_word == RW'(m_acc), "R8 dec", int'($signed(rx_word)), m_acc);
    end
    for (int i = 0; i < 135; i++) pulse(1'b1);
    chk(rx_word == RW'(AMAX), "R9 upper clamp", int'($signed(rx_word)), AMAX);
    for (int i = 0; i < 260; i++) pulse(1'b0);
    chk(rx_word == RW'(-AMAX), "R9 lower clamp", int'($signed(rx_word)), -AMAX);
    vote_late = 1'b0; test_en = 1'b0;
    m_idle = 0; m_ramp = 0;
    for (int i = 0; i < 10; i++) tick(1'b0, 1'b1, "R9 recover");
    read_acc("R9 recover");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule